// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the bytes of received frames for a wake pattern. The pattern is a run of six 0xFF bytes followed by sixteen back-to-back copies of a programmable 48-bit station address. The pattern may begin at any byte offset inside a frame. When a full pattern is seen, the block drives a dedicated active-low wake line and sets a wake status bit. The status bit also reaches a general active-low interrupt line through a mask bit.

Bytes arrive on a valid/ready stream. `rx_last` marks the final byte of each frame. The block never applies back-pressure: `rx_ready` is always high. A byte is taken on every clock edge at which `rx_valid` is high, and cycles with `rx_valid` low carry no data.

The dedicated line has two modes. In level mode it stays low until software reads the status or disables detection. In pulse mode it goes low for a programmable number of cycles. The status bit is cleared by a status read only in pulse mode.

Top module: `wake_pattern_detector`

## Requirements
- R1: After reset `wake_n` and `irq_n` are high and `wake_sts` is low.
- R2: `rx_ready` is high in every cycle; a byte is consumed on each edge where `rx_valid` is high.
- R3: The target address is `{addr_w0, addr_w1, addr_w2}`, so `addr_w0` holds bits 47:32. Address bytes go on the stream most significant byte first. When the last byte of "six 0xFF, then sixteen copies of the address" is consumed, `wake_sts` is high after that same edge. This holds wherever the pattern starts in the frame.
- R4: When the sequence breaks, matching restarts, and the breaking byte starts a new sync run if it is 0xFF. A run of more than six 0xFF bytes directly before the address copies still matches.
- R5: A frame end (`rx_last` on a consumed byte) clears partial progress. A pattern split across two frames does not match. A pattern that ends on the last byte does match.
- R6: While `wake_en` is low, nothing is detected. One edge after `wake_en` is low, `wake_n` and `wake_sts` are released.
- R7: Level mode (`pulse_mode`=0): `wake_n` goes low on the edge that completes a match. It stays low until an edge with `sts_rd` high or `wake_en` low.
- R8: Pulse mode (`pulse_mode`=1): `wake_n` is low for exactly 8, 16, 32 or 64 cycles for `pulse_len` codes 0, 1, 2 and 3.
- R9: `wake_sts` is set by a match. In pulse mode an edge with `sts_rd` high clears it. In level mode `sts_rd` leaves it set.
- R10: `irq_n` is low exactly when `wake_sts` is high and `irq_mask` is high.
- R11: Cycles with `rx_valid` low neither advance nor break a match in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_ready | output | 1 | Always high; no back-pressure |
| rx_data | input | 8 | Received frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| wake_en | input | 1 | Enables detection |
| pulse_mode | input | 1 | 0 = level wake output, 1 = pulse |
| pulse_len | input | 2 | Pulse width code |
| addr_w0 | input | 16 | Address bits 47:32 |
| addr_w1 | input | 16 | Address bits 31:16 |
| addr_w2 | input | 16 | Address bits 15:0 |
| irq_mask | input | 1 | Lets the wake status reach `irq_n` |
| sts_rd | input | 1 | Status read strobe |
| wake_n | output | 1 | Dedicated active-low wake line |
| irq_n | output | 1 | General active-low interrupt |
| wake_sts | output | 1 | Wake status bit |

## Verification
The stream is driven with a clean pattern surrounded by junk bytes. It is also driven with a nine-byte 0xFF lead-in, which separates run counting from simple restart. A corrupted address copy followed by a good pattern checks recovery after a break. A pattern split by a frame end checks that frame boundaries discard progress. Idle gaps with the valid signal low are inserted inside a pattern to show they are transparent. Each pulse-width code, level mode, disabled detection and a cleared mask are compared cycle by cycle against a queue-based reference.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hFF;
  localparam int ADDR_W = 48;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int WORD_W = 16;
endpackage

// File: rtl/wpd_matcher.sv
module wpd_matcher
  import wpd_pkg::*;
#(
  parameter int SYNC_LEN = 6,
  parameter int REPEATS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int PAT_LEN = SYNC_LEN + REPEATS * ADDR_BYTES;
  localparam int IDX_W   = $clog2(PAT_LEN);
  localparam int BS_W    = $clog2(ADDR_BYTES);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [BS_W-1:0]  bs_q, bs_d;
  logic [BYTE_W-1:0] abyte [ADDR_BYTES];
  logic [BYTE_W-1:0] expect_b;
  logic in_sync;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
    assign abyte[g] = addr[ADDR_W-1-BYTE_W*g -: BYTE_W];
  end

  assign in_sync  = (idx_q < IDX_W'(SYNC_LEN));
  assign expect_b = in_sync ? SYNC_BYTE : abyte[bs_q];

  always_comb begin
    idx_d = idx_q;
    bs_d  = bs_q;
    hit   = 1'b0;
    if (!en) begin
      idx_d = '0;
      bs_d  = '0;
    end else if (in_valid) begin
      if (in_data == expect_b) begin
        if (idx_q == IDX_W'(PAT_LEN - 1)) begin
          hit   = 1'b1;
          idx_d = '0;
          bs_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
          if (in_sync) bs_d = '0;
          else if (bs_q == BS_W'(ADDR_BYTES - 1)) bs_d = '0;
          else bs_d = bs_q + 1'b1;
        end
      end else if (in_data == SYNC_BYTE) begin
        // extra 0xFF after a full run keeps the run; otherwise it starts one
        idx_d = (idx_q == IDX_W'(SYNC_LEN)) ? IDX_W'(SYNC_LEN) : IDX_W'(1);
        bs_d  = '0;
      end else begin
        idx_d = '0;
        bs_d  = '0;
      end
      if (in_last) begin
        idx_d = '0;
        bs_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bs_q  <= '0;
    end else begin
      idx_q <= idx_d;
      bs_q  <= bs_d;
    end
  end
endmodule

// File: rtl/wpd_wake_out.sv
module wpd_wake_out #(
  parameter int BASE_PULSE = 8,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pulse_mode,
  input  logic [SEL_W-1:0] pulse_len,
  input  logic             hit,
  input  logic             release_rd,
  output logic             wake_n
);
  localparam int MAX_PULSE = BASE_PULSE << ((1 << SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_PULSE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(BASE_PULSE) << pulse_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (hit && pulse_mode)  cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (hit && !pulse_mode) lvl_q <= 1'b1;
      else if (release_rd)    lvl_q <= 1'b0;
    end
  end

  assign wake_n = !(lvl_q || (cnt_q != '0));
endmodule

// File: rtl/wpd_irq_status.sv
module wpd_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse_mode,
  input  logic hit,
  input  logic sts_rd,
  input  logic mask,
  output logic sts,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sts <= 1'b0;
    else if (!en)                  sts <= 1'b0;
    else if (hit)                  sts <= 1'b1;
    else if (sts_rd && pulse_mode) sts <= 1'b0;
  end

  assign irq_n = !(sts && mask);
endmodule

// File: rtl/wake_pattern_detector.sv
module wake_pattern_detector
  import wpd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  parameter int BASE_PULSE = 8,
  parameter int SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic              wake_en,
  input  logic              pulse_mode,
  input  logic [SEL_W-1:0]  pulse_len,
  input  logic [WORD_W-1:0] addr_w0,
  input  logic [WORD_W-1:0] addr_w1,
  input  logic [WORD_W-1:0] addr_w2,
  input  logic              irq_mask,
  input  logic              sts_rd,
  output logic              wake_n,
  output logic              irq_n,
  output logic              wake_sts
);
  logic [ADDR_W-1:0] addr;
  logic              hit;

  assign rx_ready = 1'b1;
  assign addr     = {addr_w0, addr_w1, addr_w2};

  wpd_matcher #(.SYNC_LEN(SYNC_LEN), .REPEATS(REPEATS)) u_match (
    .clk(clk), .rst_n(rst_n), .en(wake_en), .in_valid(rx_valid),
    .in_data(rx_data), .in_last(rx_last), .addr(addr), .hit(hit)
  );

  wpd_wake_out #(.BASE_PULSE(BASE_PULSE), .SEL_W(SEL_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .en(wake_en), .pulse_mode(pulse_mode),
    .pulse_len(pulse_len), .hit(hit), .release_rd(sts_rd), .wake_n(wake_n)
  );

  wpd_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .en(wake_en), .pulse_mode(pulse_mode),
    .hit(hit), .sts_rd(sts_rd), .mask(irq_mask), .sts(wake_sts), .irq_n(irq_n)
  );
endmodule

// File: rtl/wpd_checker.sv
module wpd_checker (
  input logic clk,
  input logic rst_n,
  input logic wake_en,
  input logic pulse_mode,
  input logic irq_mask,
  input logic sts_rd,
  input logic wake_n,
  input logic irq_n,
  input logic wake_sts
);
  // R6
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_en |=> (wake_n && !wake_sts));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> irq_n);

  // R9
  level_sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sts && !pulse_mode && wake_en) |=> wake_sts);

  // R3
  wake_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> wake_sts);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_n && !pulse_mode && wake_en && !sts_rd) |=> !wake_n);
endmodule

bind wake_pattern_detector wpd_checker u_wpd_chk (
  .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .pulse_mode(pulse_mode),
  .irq_mask(irq_mask), .sts_rd(sts_rd), .wake_n(wake_n), .irq_n(irq_n),
  .wake_sts(wake_sts)
);

// File: tb/test_wake_pattern_detector.sv
module test_wake_pattern_detector;
  localparam int PAT = 102;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_last = 0, wake_en = 0, pulse_mode = 0, irq_mask = 0, sts_rd = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] pulse_len = 0;
  logic [15:0] addr_w0 = 16'h1234, addr_w1 = 16'h5678, addr_w2 = 16'h9ABC;
  logic rx_ready, wake_n, irq_n, wake_sts;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R1";
  bit running = 0;

  byte unsigned q[$];
  byte unsigned pat[PAT];
  bit m_sts = 0, m_lvl = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  wake_pattern_detector i_wake_pattern_detector (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .wake_en(wake_en),
    .pulse_mode(pulse_mode), .pulse_len(pulse_len), .addr_w0(addr_w0),
    .addr_w1(addr_w1), .addr_w2(addr_w2), .irq_mask(irq_mask),
    .sts_rd(sts_rd), .wake_n(wake_n), .irq_n(irq_n), .wake_sts(wake_sts)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    bit hit, ok;
    cycles++;
    hit = 0;
    if (!rst_n) begin
      q.delete(); m_sts = 0; m_lvl = 0; m_cnt = 0;
    end else begin
      if (!wake_en) q.delete();
      else if (rx_valid) begin
        q.push_back(rx_data);
        if (q.size() > PAT) void'(q.pop_front());
        if (q.size() == PAT) begin
          ok = 1;
          for (int i = 0; i < PAT; i++) if (q[i] != pat[i]) ok = 0;
          if (ok) begin hit = 1; q.delete(); end
        end
        if (rx_last) q.delete();
      end
      if (!wake_en) begin
        m_sts = 0; m_lvl = 0; m_cnt = 0;
      end else begin
        if (hit && pulse_mode) m_cnt = 8 << pulse_len;
        else if (m_cnt > 0) m_cnt--;
        if (hit && !pulse_mode) m_lvl = 1;
        else if (sts_rd) m_lvl = 0;
        if (hit) m_sts = 1;
        else if (sts_rd && pulse_mode) m_sts = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      check(cur_tag, wake_n, !(m_lvl || m_cnt > 0), "wake_n");
      check("R9", wake_sts, m_sts, "wake_sts");
      check("R10", irq_n, !(m_sts && irq_mask), "irq_n");
      check("R2", rx_ready, 1'b1, "rx_ready");
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic put(byte unsigned b, bit last = 0);
    rx_valid = 1; rx_data = b; rx_last = last; step();
    rx_valid = 0; rx_last = 0;
  endtask
  task automatic send_pat(int ff_count = 6, bit gaps = 0, bit last_end = 0);
    for (int i = 0; i < ff_count; i++) put(8'hFF);
    for (int r = 0; r < 16; r++)
      for (int b = 0; b < 6; b++) begin
        if (gaps && (b == 2)) idle(2);
        put(pat[6 + b], last_end && r == 15 && b == 5);
      end
  endtask
  task automatic rd(); sts_rd = 1; step(); sts_rd = 0; endtask

  initial begin
    for (int i = 0; i < 6; i++) pat[i] = 8'hFF;
    for (int r = 0; r < 16; r++) begin
      pat[6+r*6+0] = 8'h12; pat[6+r*6+1] = 8'h34; pat[6+r*6+2] = 8'h56;
      pat[6+r*6+3] = 8'h78; pat[6+r*6+4] = 8'h9A; pat[6+r*6+5] = 8'hBC;
    end
    idle(3);
    rst_n = 1;
    step();
    check("R1", wake_n, 1'b1, "reset wake_n");
    check("R1", irq_n, 1'b1, "reset irq_n");
    check("R1", wake_sts, 1'b0, "reset wake_sts");
    running = 1;

    // R3 / R7 level mode, pattern mid-frame
    cur_tag = "R7"; wake_en = 1; irq_mask = 1; pulse_mode = 0;
    put(8'h01); put(8'hFF); put(8'h22);
    send_pat();
    check("R3", wake_sts, 1'b1, "match mid-frame");
    check("R7", wake_n, 1'b0, "level low");
    put(8'h33, 1); idle(5);
    rd(); idle(2);
    check("R7", wake_n, 1'b1, "level released by read");
    check("R9", wake_sts, 1'b1, "level read keeps status");
    wake_en = 0; step(); wake_en = 1; step();
    check("R6", wake_sts, 1'b0, "disable clears status");

    // R4 long sync run, then broken copy and recovery
    cur_tag = "R4";
    send_pat(9);
    check("R4", wake_sts, 1'b1, "nine FF lead-in");
    wake_en = 0; step(); wake_en = 1;
    for (int i = 0; i < 6; i++) put(8'hFF);
    for (int i = 0; i < 40; i++) put(pat[6 + i % 6]);
    put(8'hFF);
    send_pat(5);
    check("R4", wake_sts, 1'b1, "FF breaking copy starts run");
    wake_en = 0; step(); wake_en = 1;
    for (int i = 0; i < 6; i++) put(8'hFF);
    put(8'h12); put(8'h00);
    send_pat();
    check("R4", wake_sts, 1'b1, "recovery after break");
    put(8'h00, 1);
    wake_en = 0; step(); wake_en = 1;

    // R5 split across frames, then ending on last
    cur_tag = "R5";
    for (int i = 0; i < 6; i++) put(8'hFF);
    for (int i = 0; i < 48; i++) put(pat[6 + i % 6], i == 47);
    for (int i = 0; i < 48; i++) put(pat[6 + i % 6]);
    check("R5", wake_sts, 1'b0, "split frames no match");
    put(8'h00, 1);
    send_pat(6, 0, 1);
    check("R5", wake_sts, 1'b1, "match on last byte");
    wake_en = 0; step();

    // R6 disabled detection
    cur_tag = "R6";
    send_pat();
    check("R6", wake_sts, 1'b0, "disabled no match");
    check("R6", wake_n, 1'b1, "disabled wake_n");
    wake_en = 1;

    // R11 gaps
    cur_tag = "R11";
    send_pat(6, 1);
    check("R11", wake_sts, 1'b1, "gaps transparent");
    rd(); put(8'h00, 1);
    wake_en = 0; step(); wake_en = 1;

    // R8 pulse widths
    cur_tag = "R8"; pulse_mode = 1;
    for (int s = 0; s < 4; s++) begin
      pulse_len = 2'(s);
      send_pat();
      check("R8", wake_n, 1'b0, "pulse starts");
      idle((8 << s) - 1);
      check("R8", wake_n, 1'b0, "pulse last low cycle");
      step();
      check("R8", wake_n, 1'b1, "pulse ended");
      rd();
      check("R9", wake_sts, 1'b0, "pulse mode read clears");
      put(8'h00, 1);
    end

    // R10 mask off
    cur_tag = "R10"; irq_mask = 0; pulse_len = 0;
    send_pat();
    check("R10", wake_sts, 1'b1, "status set with mask off");
    check("R10", irq_n, 1'b1, "masked irq quiet");
    irq_mask = 1; step();
    check("R10", irq_n, 1'b0, "unmasked irq asserts");
    rd(); idle(10);
    check("R10", irq_n, 1'b1, "irq cleared by read");

    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule